// File: doc/BRIEF.md
# Kernel Segment Address Mapper

This block sits in front of the paged translation unit and decides how each 32-bit memory access is turned into a physical address. There are three outcomes. When translation is switched off, the address passes straight through. When a kernel access lands in a 256 MiB segment that has segment mapping enabled, the top four address bits are replaced by a per-segment base nibble. In every other case the access is handed to the paged unit, and that unit's answer is returned.

Sixteen 4-bit segment bases are packed into two 32-bit base registers. A 16-bit enable mask picks which segments are mapped. User-mode accesses never use segment mapping. The access type also selects the target unit: instruction fetches go to the instruction unit, and loads and stores go to the data unit.

The paged unit answers combinationally in the same cycle as the request. The result of every access is registered and presented one cycle after the request.

Top module: `segmap_top`

## Requirements
- R1: While reset is asserted, and until the first request is accepted, rsp_valid, rsp_paddr, rsp_perm, rsp_fault, rsp_vec and rsp_route are all zero.
- R2: When gcfg bits 2 and 3 are both clear, translation is off. The result is rsp_paddr = vaddr and rsp_perm = 3'b111 (bit 0 read, bit 1 write, bit 2 execute). It also has rsp_fault = 0, rsp_vec = 0 and rsp_route = 0 (bypass), and pg_req_valid stays low. This holds regardless of user_mode and seg_en.
- R3: Translation is on when gcfg bit 2 or gcfg bit 3 is set. The other gcfg bits have no effect.
- R4: With translation on, a kernel access (user_mode = 0) whose segment bit seg_en[vaddr[31:28]] is set is segment-mapped. Its result is rsp_paddr = {base nibble, vaddr[27:0]}, rsp_perm = 3'b111, rsp_fault = 0, rsp_vec = 0 and rsp_route = 1, and pg_req_valid stays low.
- R5: Segments 0 to 7 take their base nibble from base_lo and segments 8 to 15 from base_hi. The nibble for segment s sits at bits [(s mod 8)*4+3 : (s mod 8)*4].
- R6: With translation on, a user access (user_mode = 1) always goes to the paged path (rsp_route = 2), whatever seg_en holds.
- R7: With translation on, a kernel access whose seg_en bit is clear goes to the paged path.
- R8: For a paged access, pg_req_valid is high in the request cycle, with pg_req_addr = vaddr and pg_req_type = acc_type. In the next cycle rsp_paddr, rsp_perm, rsp_fault and rsp_vec equal the pg_paddr, pg_perm, pg_fault and pg_vec values of the request cycle, and rsp_route = 2. pg_req_valid is low in all other cycles.
- R9: acc_type uses the codes 0 = read, 1 = write, 2 = execute, and code 3 is handled as a read. pg_req_instr is 1 for execute and 0 for the other three codes.
- R10: rsp_valid is high exactly in the cycle after a cycle with req_valid high. After a cycle without a request, rsp_valid is low and the result fields keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Access request in this cycle |
| vaddr | input | 32 | Virtual address |
| acc_type | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 read |
| user_mode | input | 1 | 1 for a user-mode access, 0 for kernel mode |
| gcfg | input | 32 | Global configuration; bit 2 or bit 3 switches translation on |
| seg_en | input | 16 | Per-segment enable for kernel segment mapping |
| base_lo | input | 32 | Base nibbles for segments 0 to 7 |
| base_hi | input | 32 | Base nibbles for segments 8 to 15 |
| pg_req_valid | output | 1 | Request to the paged unit |
| pg_req_instr | output | 1 | 1 selects the instruction unit, 0 the data unit |
| pg_req_addr | output | 32 | Address forwarded to the paged unit |
| pg_req_type | output | 2 | Access type forwarded to the paged unit |
| pg_paddr | input | 32 | Physical address from the paged unit (same cycle) |
| pg_perm | input | 3 | Permissions from the paged unit |
| pg_fault | input | 1 | Fault flag from the paged unit |
| pg_vec | input | 4 | Fault vector from the paged unit |
| rsp_valid | output | 1 | Result valid |
| rsp_paddr | output | 32 | Physical address |
| rsp_perm | output | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| rsp_fault | output | 1 | Fault flag |
| rsp_vec | output | 4 | Fault vector |
| rsp_route | output | 2 | Path taken: 0 bypass, 1 segment, 2 paged |

## Verification
The paged-unit request outputs (pg_req_valid, pg_req_instr, pg_req_addr, pg_req_type) are combinational, so they are due in the same cycle as the request. The bench compares them on the rising edge, against inputs it drove at the preceding falling edge. Every rsp_* field goes through exactly one register and is due one cycle after the request. The reference model therefore computes its expectation from the inputs at the request edge, and the comparison happens at the following falling edge. The internal reset synchroniser adds two cycles after reset release, so the bench issues no request before those cycles have passed. Until the first request, it expects the reset values.

// File: rtl/segmap_pkg.sv
package segmap_pkg;

  // Path taken by an access; the encoding is visible on rsp_route.
  typedef enum logic [1:0] {
    RT_BYPASS  = 2'd0,
    RT_SEGMENT = 2'd1,
    RT_PAGED   = 2'd2
  } route_e;

  // Access type codes on acc_type.
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam int PERM_W = 3;

  // Permission bundle, bit 0 read, bit 1 write, bit 2 execute.
  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } perm_t;

  localparam perm_t PERM_ALL = '{x: 1'b1, w: 1'b1, r: 1'b1};

  // Bits of the global configuration word that switch translation on.
  localparam int XLATE_EN_LO = 2;
  localparam int XLATE_EN_HI = 3;

endpackage

// File: rtl/segmap_rst_sync.sv
module segmap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else begin
      shift_q <= {shift_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = shift_q[STAGES-1];

endmodule

// File: rtl/segmap_route_dec.sv
module segmap_route_dec
  import segmap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 4
) (
  input  logic [ADDR_W-1:0]     gcfg,
  input  logic [SEG_W-1:0]      seg,
  input  logic [2**SEG_W-1:0]   seg_en,
  input  logic                  user_mode,
  output route_e                route
);

  localparam logic [ADDR_W-1:0] EN_MASK =
    (ADDR_W'(1) << XLATE_EN_LO) | (ADDR_W'(1) << XLATE_EN_HI);

  logic xlate_on;
  logic seg_hit;

  assign xlate_on = |(gcfg & EN_MASK);
  assign seg_hit  = seg_en[seg] & ~user_mode;

  always_comb begin
    if (!xlate_on) begin
      route = RT_BYPASS;
    end else if (seg_hit) begin
      route = RT_SEGMENT;
    end else begin
      route = RT_PAGED;
    end
  end

endmodule

// File: rtl/segmap_base_sel.sv
module segmap_base_sel #(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 4
) (
  input  logic [ADDR_W-1:0] base_lo,
  input  logic [ADDR_W-1:0] base_hi,
  input  logic [SEG_W-1:0]  seg,
  output logic [SEG_W-1:0]  base_nib
);

  localparam int NSEG    = 2**SEG_W;
  localparam int NIB_REG = ADDR_W / SEG_W;

  logic [SEG_W-1:0] nib_tab [NSEG];

  // Segment g reads nibble (g mod NIB_REG) of the low or high word.
  for (genvar g = 0; g < NSEG; g++) begin : g_nib
    if (g < NIB_REG) begin : g_lo
      assign nib_tab[g] = base_lo[g*SEG_W +: SEG_W];
    end else begin : g_hi
      assign nib_tab[g] = base_hi[(g-NIB_REG)*SEG_W +: SEG_W];
    end
  end

  assign base_nib = nib_tab[seg];

endmodule

// File: rtl/segmap_unit_sel.sv
module segmap_unit_sel
  import segmap_pkg::*;
(
  input  logic [1:0] acc_type,
  output logic       is_instr
);

  always_comb begin
    unique case (acc_e'(acc_type))
      ACC_EXEC: is_instr = 1'b1;
      default:  is_instr = 1'b0;
    endcase
  end

endmodule

// File: rtl/segmap_top.sv
module segmap_top
  import segmap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 4,
  parameter int VEC_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    vaddr,
  input  logic [1:0]           acc_type,
  input  logic                 user_mode,
  input  logic [ADDR_W-1:0]    gcfg,
  input  logic [2**SEG_W-1:0]  seg_en,
  input  logic [ADDR_W-1:0]    base_lo,
  input  logic [ADDR_W-1:0]    base_hi,
  output logic                 pg_req_valid,
  output logic                 pg_req_instr,
  output logic [ADDR_W-1:0]    pg_req_addr,
  output logic [1:0]           pg_req_type,
  input  logic [ADDR_W-1:0]    pg_paddr,
  input  logic [PERM_W-1:0]    pg_perm,
  input  logic                 pg_fault,
  input  logic [VEC_W-1:0]     pg_vec,
  output logic                 rsp_valid,
  output logic [ADDR_W-1:0]    rsp_paddr,
  output logic [PERM_W-1:0]    rsp_perm,
  output logic                 rsp_fault,
  output logic [VEC_W-1:0]     rsp_vec,
  output logic [1:0]           rsp_route
);

  localparam int OFS_W = ADDR_W - SEG_W;

  logic             rst_sync_n;
  logic [SEG_W-1:0] seg;
  logic [SEG_W-1:0] base_nib;
  route_e           route;
  logic             is_instr;

  logic [ADDR_W-1:0] nxt_paddr;
  perm_t             nxt_perm;
  logic              nxt_fault;
  logic [VEC_W-1:0]  nxt_vec;
  route_e            nxt_route;

  logic              valid_q;
  logic [ADDR_W-1:0] paddr_q;
  perm_t             perm_q;
  logic              fault_q;
  logic [VEC_W-1:0]  vec_q;
  route_e            route_q;

  assign seg = vaddr[ADDR_W-1 -: SEG_W];

  segmap_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  segmap_route_dec #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_route_dec (
    .gcfg      (gcfg),
    .seg       (seg),
    .seg_en    (seg_en),
    .user_mode (user_mode),
    .route     (route)
  );

  segmap_base_sel #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_base_sel (
    .base_lo  (base_lo),
    .base_hi  (base_hi),
    .seg      (seg),
    .base_nib (base_nib)
  );

  segmap_unit_sel u_unit_sel (
    .acc_type (acc_type),
    .is_instr (is_instr)
  );

  // Requests towards the paged unit (same cycle).
  assign pg_req_valid = req_valid & (route == RT_PAGED);
  assign pg_req_instr = is_instr;
  assign pg_req_addr  = vaddr;
  assign pg_req_type  = acc_type;

  // Next-state result.
  always_comb begin
    nxt_paddr = vaddr;
    nxt_perm  = PERM_ALL;
    nxt_fault = 1'b0;
    nxt_vec   = '0;
    nxt_route = route;
    unique case (route)
      RT_SEGMENT: begin
        nxt_paddr = {base_nib, vaddr[OFS_W-1:0]};
      end
      RT_PAGED: begin
        nxt_paddr = pg_paddr;
        nxt_perm  = perm_t'(pg_perm);
        nxt_fault = pg_fault;
        nxt_vec   = pg_vec;
      end
      default: begin
        nxt_paddr = vaddr;
      end
    endcase
  end

  // Result registers.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= req_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      paddr_q <= '0;
      perm_q  <= '0;
      fault_q <= 1'b0;
      vec_q   <= '0;
      route_q <= RT_BYPASS;
    end else if (req_valid) begin
      paddr_q <= nxt_paddr;
      perm_q  <= nxt_perm;
      fault_q <= nxt_fault;
      vec_q   <= nxt_vec;
      route_q <= nxt_route;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_paddr = paddr_q;
  assign rsp_perm  = perm_q;
  assign rsp_fault = fault_q;
  assign rsp_vec   = vec_q;
  assign rsp_route = route_q;

endmodule

// File: rtl/segmap_chk.sv
module segmap_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] vaddr,
  input logic [1:0]        acc_type,
  input logic              user_mode,
  input logic [1:0]        en_bits,
  input logic              pg_req_valid,
  input logic              pg_req_instr,
  input logic [ADDR_W-1:0] pg_paddr,
  input logic              pg_fault,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic [2:0]        rsp_perm,
  input logic              rsp_fault,
  input logic [1:0]        rsp_route
);

  assert_bypass_identity_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && en_bits == 2'b00) |=>
      (rsp_paddr == $past(vaddr) && rsp_perm == 3'b111 && !rsp_fault && rsp_route == 2'd0));

  assert_enable_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && en_bits != 2'b00) |=> (rsp_route != 2'd0));

  assert_seg_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pg_req_valid && en_bits != 2'b00) |=>
      (rsp_paddr[ADDR_W-5:0] == $past(vaddr[ADDR_W-5:0]) && rsp_perm == 3'b111 && !rsp_fault));

  assert_user_paged_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && user_mode && en_bits != 2'b00) |-> pg_req_valid);

  assert_paged_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pg_req_valid |=> (rsp_paddr == $past(pg_paddr) && rsp_fault == $past(pg_fault) && rsp_route == 2'd2));

  assert_paged_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !pg_req_valid);

  assert_exec_instr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_req_valid && acc_type == 2'd2) |-> pg_req_instr);

  assert_data_unit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_req_valid && acc_type != 2'd2) |-> !pg_req_instr);

  assert_valid_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && $stable(rsp_paddr) && $stable(rsp_route)));

endmodule

bind segmap_top segmap_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .req_valid    (req_valid),
  .vaddr        (vaddr),
  .acc_type     (acc_type),
  .user_mode    (user_mode),
  .en_bits      (gcfg[3:2]),
  .pg_req_valid (pg_req_valid),
  .pg_req_instr (pg_req_instr),
  .pg_paddr     (pg_paddr),
  .pg_fault     (pg_fault),
  .rsp_valid    (rsp_valid),
  .rsp_paddr    (rsp_paddr),
  .rsp_perm     (rsp_perm),
  .rsp_fault    (rsp_fault),
  .rsp_route    (rsp_route)
);

// File: tb/segmap_top_tb.sv
module segmap_top_tb;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        req_valid;
  logic [31:0] vaddr;
  logic [1:0]  acc_type;
  logic        user_mode;
  logic [31:0] gcfg;
  logic [15:0] seg_en;
  logic [31:0] base_lo;
  logic [31:0] base_hi;
  logic        pg_req_valid;
  logic        pg_req_instr;
  logic [31:0] pg_req_addr;
  logic [1:0]  pg_req_type;
  logic [31:0] pg_paddr;
  logic [2:0]  pg_perm;
  logic        pg_fault;
  logic [3:0]  pg_vec;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_perm;
  logic        rsp_fault;
  logic [3:0]  rsp_vec;
  logic [1:0]  rsp_route;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;
  string cur_tag = "R1";

  segmap_top u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .vaddr(vaddr),
    .acc_type(acc_type), .user_mode(user_mode), .gcfg(gcfg), .seg_en(seg_en),
    .base_lo(base_lo), .base_hi(base_hi),
    .pg_req_valid(pg_req_valid), .pg_req_instr(pg_req_instr),
    .pg_req_addr(pg_req_addr), .pg_req_type(pg_req_type),
    .pg_paddr(pg_paddr), .pg_perm(pg_perm), .pg_fault(pg_fault), .pg_vec(pg_vec),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm),
    .rsp_fault(rsp_fault), .rsp_vec(rsp_vec), .rsp_route(rsp_route)
  );

  // Stand-in paged unit: answers in the same cycle.
  always_comb begin
    if (pg_req_valid) begin
      pg_paddr = pg_req_addr ^ 32'h5A5A_0000;
      pg_perm  = pg_req_addr[8:6];
      pg_fault = pg_req_addr[3];
      pg_vec   = (pg_req_instr ? 4'd4 : 4'd8) + {2'b00, pg_req_addr[5:4]};
    end else begin
      pg_paddr = '0;
      pg_perm  = '0;
      pg_fault = 1'b0;
      pg_vec   = '0;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Reference model: expected registered result, and same-cycle request checks.
  logic        e_valid = 1'b0;
  logic [31:0] e_paddr = '0;
  logic [2:0]  e_perm  = '0;
  logic        e_fault = 1'b0;
  logic [3:0]  e_vec   = '0;
  logic [1:0]  e_route = '0;
  string       e_tag   = "R1";

  always @(posedge clk) begin
    int   seg;
    bit   en;
    bit   want_pg;
    logic [31:0] breg;
    logic [3:0]  nib;
    if (!rst_n) begin
      e_valid = 1'b0; e_paddr = '0; e_perm = '0; e_fault = 1'b0;
      e_vec = '0; e_route = '0; e_tag = "R1";
    end else if (!req_valid) begin
      e_valid = 1'b0;
      if (e_tag != "R1") e_tag = "R10";
      chk(pg_req_valid == 1'b0, "R8", "pg_req_valid idle",
          64'(pg_req_valid), 64'd0);
    end else begin
      e_valid = 1'b1;
      e_tag   = cur_tag;
      seg     = int'(vaddr >> 28);
      en      = gcfg[2] || gcfg[3];
      want_pg = en && !(!user_mode && seg_en[seg]);
      if (!en) begin
        e_paddr = vaddr; e_perm = 3'b111; e_fault = 1'b0; e_vec = '0; e_route = 2'd0;
      end else if (!want_pg) begin
        breg    = (seg < 8) ? base_lo : base_hi;
        nib     = 4'((breg >> ((seg % 8) * 4)) & 32'hF);
        e_paddr = {nib, vaddr[27:0]};
        e_perm = 3'b111; e_fault = 1'b0; e_vec = '0; e_route = 2'd1;
      end else begin
        e_paddr = vaddr ^ 32'h5A5A_0000;
        e_perm  = vaddr[8:6];
        e_fault = vaddr[3];
        e_vec   = ((acc_type == 2'd2) ? 4'd4 : 4'd8) + {2'b00, vaddr[5:4]};
        e_route = 2'd2;
      end
      chk(pg_req_valid == want_pg &&
          (!want_pg || (pg_req_addr == vaddr && pg_req_type == acc_type &&
                        pg_req_instr == (acc_type == 2'd2))),
          want_pg ? "R9" : "R8", "paged request {valid,instr,type}",
          {59'd0, pg_req_valid, pg_req_instr, pg_req_type, 1'b0},
          {59'd0, want_pg, (acc_type == 2'd2), acc_type, 1'b0});
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk({rsp_valid, rsp_paddr, rsp_perm, rsp_fault, rsp_vec, rsp_route} ==
          {e_valid, e_paddr, e_perm, e_fault, e_vec, e_route},
          e_tag, "{valid,paddr,perm,fault,vec,route}",
          {21'd0, rsp_valid, rsp_paddr, rsp_perm, rsp_fault, rsp_vec, rsp_route},
          {21'd0, e_valid, e_paddr, e_perm, e_fault, e_vec, e_route});
    end
  end

  task automatic issue(input logic [31:0] a, input logic [1:0] t,
                       input logic u, input string tag);
    @(negedge clk);
    req_valid = 1'b1; vaddr = a; acc_type = t; user_mode = u; cur_tag = tag;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      vaddr     = ~vaddr;
      acc_type  = acc_type + 2'd1;
      user_mode = ~user_mode;
    end
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; vaddr = '0; acc_type = '0; user_mode = 1'b0;
    gcfg = '0; seg_en = '0; base_lo = '0; base_hi = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R2: translation off, even with every segment enabled.
    gcfg = 32'h0; seg_en = 16'hFFFF;
    base_lo = 32'h89AB_CDEF; base_hi = 32'h1357_9BDF;
    issue(32'h1234_5678, 2'd0, 1'b0, "R2");
    issue(32'hF000_0ABC, 2'd2, 1'b1, "R2");
    issue(32'h8765_4321, 2'd1, 1'b0, "R2");
    idle(2);

    // R3: only bits 2 and 3 switch translation on.
    gcfg = 32'hFFFF_FFF3;
    issue(32'h3000_1000, 2'd0, 1'b0, "R3");
    gcfg = 32'h0000_0004;
    issue(32'h3000_1000, 2'd0, 1'b0, "R3");
    gcfg = 32'h0000_0008;
    issue(32'h3000_1000, 2'd1, 1'b1, "R3");
    idle(1);

    // R4, R5: every segment mapped in kernel mode.
    gcfg = 32'h4;
    for (int s = 0; s < 16; s++) begin
      issue({4'(s), 28'h0ABC_DEF ^ (28'h011_1111 * 28'(s))}, 2'(s % 3), 1'b0,
            (s < 8) ? "R5" : "R4");
    end
    idle(3);

    // R6: user mode ignores the segment mask.
    issue(32'h2000_00F8, 2'd0, 1'b1, "R6");
    issue(32'hA123_4568, 2'd1, 1'b1, "R6");
    issue(32'hF00D_0170, 2'd2, 1'b1, "R6");
    idle(1);

    // R7: kernel access, partial segment mask.
    seg_en = 16'h00F0;
    issue(32'h2000_0148, 2'd0, 1'b0, "R7");
    issue(32'h5ABC_0148, 2'd0, 1'b0, "R7");
    issue(32'h9000_01F0, 2'd1, 1'b0, "R7");
    issue(32'hF777_7778, 2'd2, 1'b0, "R7");
    idle(2);

    // R9: unit selection for all four type codes on the paged path.
    seg_en = 16'h0000;
    issue(32'hC000_0030, 2'd0, 1'b0, "R9");
    issue(32'hC000_0030, 2'd1, 1'b0, "R9");
    issue(32'hC000_0030, 2'd2, 1'b0, "R9");
    issue(32'hC000_0030, 2'd3, 1'b0, "R9");

    // R10: idle cycles keep the last result while inputs move.
    idle(5);
    issue(32'h0000_0010, 2'd2, 1'b1, "R10");
    idle(3);

    done = 1'b1;
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule